// File: doc/BRIEF.md
# Presence-Detect Memory Target on a Two-Wire Bus

This block is the target side of a two-wire serial bus (I2C) that exposes a 256-byte identification memory. The host addresses it with a seven-bit bus address whose upper four bits are fixed by a parameter and whose lower three bits come from board strap pins. Through that address the host can set an internal word pointer, write single bytes, and read one or more bytes in sequence from the pointer. The pointer can be set first and then followed by a repeated start and a read, which gives a random read.

The memory has two halves. The lower half holds identification data that is fixed when the block leaves reset: it is computed from a seed parameter and ends in a checksum byte. The upper half is free for the system to use. It can be written only while the protect pin is low. After each stop that closes a transaction containing a data write, the target stays off the bus for a programmed number of clocks. During that time it does not answer its own address.

Both bus lines are resynchronised and majority-voted before any edge is detected, so one-sample spikes do not count as bus events. The target only ever pulls SDA low and never stretches SCL.

Top module: `spd_i2c_target`

## Requirements
- R1: The target acknowledges an address byte only when bits 7:4 equal DEV_TYPE (default 4'b1010) and bits 3:1 equal strap_i[2:0]. Bit 0 selects the direction, with 1 meaning read. For any other address it never drives SDA low for the rest of that transaction.
- R2: After reset, byte j for j in 0..127, except byte 63, equals (SEED + 3*j) mod 256. Byte 63 equals the mod-256 sum of bytes 0..62. Bytes 128..255 read as 8'hFF.
- R3: In a write transaction, the first byte after the address loads the word pointer. Each following data byte is stored at the pointer when the pointer's bit 7 is 1 and wp_i is 0.
- R4: A data byte aimed at addresses 0..127 is acknowledged, and the stored byte does not change.
- R5: A data byte aimed at addresses 128..255 while wp_i is 1 is acknowledged, and the stored byte does not change.
- R6: In a read, the target sends the byte at the pointer MSB first and then advances the pointer. It keeps sending successive bytes while the host acknowledges. After a host NACK it releases SDA until the next start or stop.
- R7: A pointer write followed by a repeated start and a read address returns the byte at the loaded pointer. A read with no pointer write resumes from the current pointer.
- R8: The pointer advances after every byte read or written and wraps from 255 to 0.
- R9: After a stop that ends a transaction containing at least one data byte, the target NACKs its own address for BUSY_CYCLES clocks. After that it acknowledges again.
- R10: A pulse on SCL or SDA that lasts one clock sample is not treated as a bus edge.
- R11: During and right after reset, sda_oe_o is 0.
- R12: sda_oe_o changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_i | input | 3 | Board straps forming address bits 3:1 |
| wp_i | input | 1 | 1 blocks writes to the upper half |

## Verification
A table of pointer writes and random reads covers three kinds of target address: seed-derived bytes in the locked half, the reset value of the open half, and writes to the locked half, the open half, and the protected open half. Each write is read back, which separates "stored" from "acknowledged but dropped". Directed sequences then exercise multi-byte reads that run across the checksum byte and across the 255-to-0 wrap. They also cover a multi-byte write that wraps, followed by a read with no pointer write, which shows where the pointer ended up. A wrong strap address is used to tell address decoding apart from general acknowledgement. An address sent straight after a write tells the busy window apart from the idle state. A one-sample SCL spike inside a pointer byte shows whether the filter kept the bit count intact.

// File: rtl/spd_pkg.sv
package spd_pkg;

  localparam int ADDR_W = 8;
  localparam int BYTE_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int HALF   = DEPTH / 2;
  localparam int CKSUM_IDX = 63;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_WAIT
  } bus_state_e;

  // seed-derived identification byte before checksum insertion
  function automatic logic [BYTE_W-1:0] seed_byte(input logic [BYTE_W-1:0] seed, input int idx);
    return seed + BYTE_W'(3 * idx);
  endfunction

  // reset content of one location
  function automatic logic [BYTE_W-1:0] init_byte(input logic [BYTE_W-1:0] seed, input int idx);
    logic [BYTE_W-1:0] sum;
    sum = '0;
    if (idx >= HALF) return '1;
    if (idx == CKSUM_IDX) begin
      for (int j = 0; j < CKSUM_IDX; j++) sum = sum + seed_byte(seed, j);
      return sum;
    end
    return seed_byte(seed, idx);
  endfunction

endpackage

// File: rtl/spd_glitch_filter.sv
module spd_glitch_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int VOTE_TAPS   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int NEED = VOTE_TAPS / 2 + 1;
  localparam int CW   = $clog2(VOTE_TAPS + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [VOTE_TAPS-1:0]   tap_q;
  logic [CW-1:0]          ones;
  logic                   vote_d;

  always_comb begin
    ones = '0;
    for (int i = 0; i < VOTE_TAPS; i++) ones = ones + CW'(tap_q[i]);
    vote_d = (int'(ones) >= NEED);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      tap_q  <= '1;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      tap_q  <= {tap_q[VOTE_TAPS-2:0], sync_q[SYNC_STAGES-1]};
      line_o <= vote_d;
    end
  end

  // R10
  filt_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(line_o) |-> (line_o == $past(tap_q[0])));

endmodule

// File: rtl/spd_store.sv
module spd_store import spd_pkg::*; #(
  parameter logic [BYTE_W-1:0] SEED = 8'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              wp_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o
);
  logic [BYTE_W-1:0] mem_q [DEPTH];
  logic              wr_ok;

  always_comb wr_ok = wr_en_i && wr_addr_i[ADDR_W-1] && !wp_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= init_byte(SEED, i);
    end else if (wr_ok) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];

  // R4 R5
  locked_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && (!wr_addr_i[ADDR_W-1] || wp_i)) |=>
      (mem_q[$past(wr_addr_i)] == $past(mem_q[wr_addr_i])));

  // R3
  open_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i[ADDR_W-1] && !wp_i) |=>
      (mem_q[$past(wr_addr_i)] == $past(wr_data_i)));

endmodule

// File: rtl/spd_bus_ctrl.sv
module spd_bus_ctrl import spd_pkg::*; #(
  parameter logic [3:0] DEV_TYPE    = 4'hA,
  parameter int         BUSY_CYCLES = 750000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        strap_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_oe_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic [ADDR_W-1:0] rd_addr_o
);
  localparam int BW = $clog2(BUSY_CYCLES + 1);

  bus_state_e        state_q, state_d;
  logic [3:0]        bit_q, bit_d;
  logic [BYTE_W-2:0] shift_q, shift_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              ack_q, ack_d;
  logic              rd_q, rd_d;
  logic              oe_q, oe_d;
  logic              wrote_q, wrote_d;
  logic [BW-1:0]     busy_q, busy_d;
  logic              scl_prev_q, sda_prev_q;
  logic              scl_rise, scl_fall, start_ev, stop_ev, busy;
  logic [BYTE_W-1:0] byte_in;
  logic              wr_en;

  always_comb begin
    scl_rise = scl_i & ~scl_prev_q;
    scl_fall = ~scl_i & scl_prev_q;
    start_ev = scl_i & scl_prev_q & sda_prev_q & ~sda_i;
    stop_ev  = scl_i & scl_prev_q & ~sda_prev_q & sda_i;
    busy     = |busy_q;
    byte_in  = {shift_q, sda_i};
  end

  always_comb begin
    state_d = state_q;  bit_d = bit_q;    shift_d = shift_q;
    tx_d    = tx_q;     ptr_d = ptr_q;    ack_d   = ack_q;
    rd_d    = rd_q;     oe_d  = oe_q;     wrote_d = wrote_q;
    busy_d  = busy ? busy_q - BW'(1) : busy_q;
    wr_en   = 1'b0;
    if (stop_ev) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
      wrote_d = 1'b0;
      if (wrote_q) busy_d = BW'(BUSY_CYCLES);
    end else if (start_ev) begin
      state_d = ST_ADDR;
      bit_d   = '0;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_PTR, ST_WR: begin
          if (scl_rise) begin
            shift_d = byte_in[BYTE_W-2:0];
            bit_d   = bit_q + 4'd1;
            if (bit_q == 4'd7) begin
              bit_d = '0;
              ack_d = 1'b1;
              if (state_q == ST_ADDR) begin
                ack_d   = (byte_in[7:1] == {DEV_TYPE, strap_i}) && !busy;
                rd_d    = byte_in[0];
                state_d = ST_ADDR_ACK;
              end else if (state_q == ST_PTR) begin
                ptr_d   = byte_in;
                state_d = ST_PTR_ACK;
              end else begin
                wr_en   = 1'b1;
                ptr_d   = ptr_q + ADDR_W'(1);
                wrote_d = 1'b1;
                state_d = ST_WR_ACK;
              end
            end
          end
        end
        ST_ADDR_ACK, ST_PTR_ACK, ST_WR_ACK: begin
          if (scl_fall) begin
            if (bit_q == 4'd0) begin
              oe_d  = ack_q;
              bit_d = 4'd1;
            end else begin
              bit_d = '0;
              oe_d  = 1'b0;
              if (state_q != ST_ADDR_ACK) begin
                state_d = ST_WR;
              end else if (!ack_q) begin
                state_d = ST_WAIT;
              end else if (rd_q) begin
                state_d = ST_RD;
                tx_d    = rd_data_i;
                oe_d    = ~rd_data_i[BYTE_W-1];
                ptr_d   = ptr_q + ADDR_W'(1);
              end else begin
                state_d = ST_PTR;
              end
            end
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            bit_d = bit_q + 4'd1;
          end else if (scl_fall) begin
            if (bit_q == 4'd8) begin
              state_d = ST_RD_ACK;
              oe_d    = 1'b0;
              bit_d   = '0;
            end else begin
              tx_d = {tx_q[BYTE_W-2:0], 1'b0};
              oe_d = ~tx_q[BYTE_W-2];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            ack_d = ~sda_i;
          end else if (scl_fall) begin
            if (ack_q) begin
              state_d = ST_RD;
              tx_d    = rd_data_i;
              oe_d    = ~rd_data_i[BYTE_W-1];
              ptr_d   = ptr_q + ADDR_W'(1);
            end else begin
              state_d = ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      bit_q      <= '0;
      shift_q    <= '0;
      tx_q       <= '0;
      ptr_q      <= '0;
      ack_q      <= 1'b0;
      rd_q       <= 1'b0;
      oe_q       <= 1'b0;
      wrote_q    <= 1'b0;
      busy_q     <= '0;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      state_q    <= state_d;
      bit_q      <= bit_d;
      shift_q    <= shift_d;
      tx_q       <= tx_d;
      ptr_q      <= ptr_d;
      ack_q      <= ack_d;
      rd_q       <= rd_d;
      oe_q       <= oe_d;
      wrote_q    <= wrote_d;
      busy_q     <= busy_d;
      scl_prev_q <= scl_i;
      sda_prev_q <= sda_i;
    end
  end

  assign sda_oe_o  = oe_q;
  assign wr_en_o   = wr_en;
  assign wr_addr_o = ptr_q;
  assign wr_data_o = byte_in;
  assign rd_addr_o = ptr_q;

  // R1
  addr_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDR && scl_rise && !start_ev && !stop_ev && bit_q == 4'd7 &&
     byte_in[7:1] != {DEV_TYPE, strap_i}) |=> !ack_q);

  // R9
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && state_q == ST_ADDR_ACK) |-> !oe_q);

  // R8
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ptr_q == '1) |=> (ptr_q == '0));

  // R12
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> !scl_i);

endmodule

// File: rtl/spd_i2c_target.sv
module spd_i2c_target import spd_pkg::*; #(
  parameter logic [3:0]        DEV_TYPE    = 4'hA,
  parameter logic [BYTE_W-1:0] SEED        = 8'h5A,
  parameter int                BUSY_CYCLES = 750000,
  parameter int                SYNC_STAGES = 2,
  parameter int                VOTE_TAPS   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] strap_i,
  input  logic       wp_i
);
  localparam int LINES = 2;

  logic [1:0]        rst_q;
  logic              rst_sync_n;
  logic [LINES-1:0]  raw_lines, filt_lines;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [BYTE_W-1:0] wr_data, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync_n = rst_q[1];

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    spd_glitch_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .VOTE_TAPS  (VOTE_TAPS)
    ) u_filt (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .line_i(raw_lines[g]),
      .line_o(filt_lines[g])
    );
  end

  spd_bus_ctrl #(
    .DEV_TYPE   (DEV_TYPE),
    .BUSY_CYCLES(BUSY_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .scl_i    (filt_lines[0]),
    .sda_i    (filt_lines[1]),
    .strap_i  (strap_i),
    .rd_data_i(rd_data),
    .sda_oe_o (sda_oe_o),
    .wr_en_o  (wr_en),
    .wr_addr_o(wr_addr),
    .wr_data_o(wr_data),
    .rd_addr_o(rd_addr)
  );

  spd_store #(
    .SEED(SEED)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .wp_i     (wp_i),
    .rd_addr_i(rd_addr),
    .rd_data_o(rd_data)
  );

endmodule

// File: tb/sim_spd_i2c_target.sv
module sim_spd_i2c_target;
  localparam int Q    = 12;
  localparam int BUSY = 3000;
  localparam logic [7:0] SEED  = 8'h5A;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] WADR  = {4'hA, STRAP, 1'b0};
  localparam logic [7:0] RADR  = {4'hA, STRAP, 1'b1};
  localparam int NV = 11;

  // {tag[3:0], write, wp, ptr[7:0], data[7:0]}
  localparam logic [21:0] VEC [NV] = '{
    {4'd2, 1'b0, 1'b0, 8'h00, 8'h5A},  // R2 first locked byte
    {4'd2, 1'b0, 1'b0, 8'h10, 8'h8A},  // R2 seed step
    {4'd2, 1'b0, 1'b0, 8'h80, 8'hFF},  // R2 open half reset value
    {4'd3, 1'b1, 1'b0, 8'h80, 8'h3C},  // R3 open write
    {4'd3, 1'b0, 1'b0, 8'h80, 8'h3C},  // R3 readback
    {4'd4, 1'b1, 1'b0, 8'h05, 8'h00},  // R4 locked write
    {4'd4, 1'b0, 1'b0, 8'h05, 8'h69},  // R4 unchanged
    {4'd5, 1'b1, 1'b1, 8'h90, 8'h77},  // R5 protected write
    {4'd5, 1'b0, 1'b0, 8'h90, 8'hFF},  // R5 unchanged
    {4'd3, 1'b1, 1'b0, 8'hFF, 8'hA5},  // R3 top byte
    {4'd3, 1'b0, 1'b0, 8'hFF, 8'hA5}   // R3 readback
  };

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;
  int   total = 0, bad = 0, edge_viol = 0;
  logic oe_prev = 1'b0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  spd_i2c_target #(
    .DEV_TYPE(4'hA), .SEED(SEED), .BUSY_CYCLES(BUSY)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .strap_i(STRAP), .wp_i(wp)
  );

  // R12 observer: drive changes while the raw clock line is high
  always @(negedge clk) begin
    if (rst_n && (sda_oe !== oe_prev) && scl_m) edge_viol++;
    oe_prev = sda_oe;
  end

  function automatic logic [7:0] exp_low(input int j);
    logic [7:0] s;
    s = '0;
    if (j == 63) begin
      for (int k = 0; k < 63; k++) s = s + SEED + 8'(3 * k);
      return s;
    end
    return SEED + 8'(3 * j);
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic bit_cell(input logic b, input bit glitch, output logic s);
    tick(Q);
    sda_m = b;
    if (glitch) begin
      tick(Q / 2);
      scl_m = 1'b1; tick(1);
      scl_m = 1'b0; tick(Q - Q / 2 - 1);
    end else begin
      tick(Q);
    end
    scl_m = 1'b1; tick(Q);
    s = sda_line; tick(Q);
    scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) bit_cell(b[i], glitch && (i == 3), s);
    bit_cell(1'b1, 1'b0, s);
    acked = ~s;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_cell(1'b1, 1'b0, s);
      d[i] = s;
    end
    bit_cell(~mack, 1'b0, s);
  endtask

  task automatic rand_read(input logic [7:0] p, input bit glitch, output logic [7:0] d, output logic acks);
    logic a1, a2, a3;
    bus_start(); send_byte(WADR, 1'b0, a1); send_byte(p, glitch, a2);
    bus_start(); send_byte(RADR, 1'b0, a3);
    recv_byte(1'b0, d); bus_stop();
    acks = a1 & a2 & a3;
  endtask

  task automatic write_one(input logic [7:0] p, input logic [7:0] v, output logic acks);
    logic a1, a2, a3;
    bus_start(); send_byte(WADR, 1'b0, a1); send_byte(p, 1'b0, a2);
    send_byte(v, 1'b0, a3); bus_stop();
    acks = a1 & a2 & a3;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [7:0] d;
    logic a, a2;
    tick(3);
    check("R11 oe in reset", 32'(sda_oe), 32'd0);
    rst_n = 1'b1;
    tick(5);
    check("R11 oe after reset", 32'(sda_oe), 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [21:0] v;
      string tg;
      v  = VEC[i];
      tg = $sformatf("R%0d vector %0d", v[21:18], i);
      wp = v[16];
      if (v[17]) begin
        write_one(v[15:8], v[7:0], a);
        check({tg, " ack"}, 32'(a), 32'd1);
        tick(BUSY + 200);
      end else begin
        rand_read(v[15:8], 1'b0, d, a);
        check({tg, " ack"}, 32'(a), 32'd1);
        check({tg, " data"}, 32'(d), 32'(v[7:0]));
      end
      wp = 1'b0;
    end

    // R2 checksum byte, R7 random read
    rand_read(8'd63, 1'b0, d, a);
    check("R2 checksum byte", 32'(d), 32'(exp_low(63)));
    check("R7 random read acks", 32'(a), 32'd1);

    // R6 sequential read across the checksum byte
    bus_start(); send_byte(WADR, 1'b0, a); send_byte(8'h3D, 1'b0, a);
    bus_start(); send_byte(RADR, 1'b0, a);
    recv_byte(1'b1, d); check("R6 seq byte 0", 32'(d), 32'(exp_low(61)));
    recv_byte(1'b1, d); check("R6 seq byte 1", 32'(d), 32'(exp_low(62)));
    recv_byte(1'b0, d); check("R6 seq byte 2", 32'(d), 32'(exp_low(63)));
    tick(Q);
    check("R6 released after nack", 32'(sda_oe), 32'd0);
    bus_stop();

    // R8 read wrap 255 -> 0
    bus_start(); send_byte(WADR, 1'b0, a); send_byte(8'hFF, 1'b0, a);
    bus_start(); send_byte(RADR, 1'b0, a);
    recv_byte(1'b1, d); check("R8 read at 255", 32'(d), 32'hA5);
    recv_byte(1'b0, d); check("R8 read wrapped to 0", 32'(d), 32'(exp_low(0)));
    bus_stop();

    // R8 write wrap, then R7 current-pointer read
    bus_start(); send_byte(WADR, 1'b0, a); send_byte(8'hFF, 1'b0, a);
    send_byte(8'h33, 1'b0, a); send_byte(8'h44, 1'b0, a2); bus_stop();
    check("R4 wrapped locked write acked", 32'(a2), 32'd1);
    tick(BUSY + 200);
    bus_start(); send_byte(RADR, 1'b0, a); recv_byte(1'b0, d); bus_stop();
    check("R8 pointer after wrapped write", 32'(d), 32'(exp_low(1)));
    check("R7 current read ack", 32'(a), 32'd1);
    rand_read(8'hFF, 1'b0, d, a);
    check("R8 byte 255 written", 32'(d), 32'h33);
    rand_read(8'h00, 1'b0, d, a);
    check("R4 byte 0 kept", 32'(d), 32'(exp_low(0)));

    // R1 wrong strap address
    bus_start(); send_byte({4'hA, 3'b100, 1'b0}, 1'b0, a);
    check("R1 foreign address nack", 32'(a), 32'd0);
    send_byte(8'h00, 1'b0, a);
    check("R1 silent for rest", 32'(a), 32'd0);
    bus_stop();

    // R9 busy window after a write
    write_one(8'hC0, 8'h11, a);
    bus_start(); send_byte(WADR, 1'b0, a); bus_stop();
    check("R9 nack while busy", 32'(a), 32'd0);
    tick(BUSY + 200);
    rand_read(8'hC0, 1'b0, d, a);
    check("R9 ack after busy", 32'(a), 32'd1);
    check("R9 data after busy", 32'(d), 32'h11);

    // R10 one-sample spike on SCL inside the pointer byte
    rand_read(8'h10, 1'b1, d, a);
    check("R10 spike ignored data", 32'(d), 32'(exp_low(16)));
    check("R10 spike ignored ack", 32'(a), 32'd1);

    check("R12 no drive change with SCL high", 32'(edge_viol), 32'd0);
    finish_run();
  end

endmodule